// File: doc/BRIEF.md
# Shared Buffer-Memory Page Map Translator

This block sits between two requesters, a network controller and a host bus, and the on-board buffer RAM that both of them use. Each requester presents a 24-bit byte address. The block drops the upper address nibble and uses the next ten bits to pick one of 1024 slots in a page map that the host can write. Each slot holds a physical frame number, a bit that routes the access either to on-board memory or to a secondary memory bus, and a byte-order bit. The block joins the frame number to the in-page offset to form a physical halfword address. It also produces byte-lane enables and write data steered for the chosen byte order.

Both requesters look up the same map in the same clock cycle, through separate read paths, so no arbitration is needed. Each request returns its result one clock later. A per-port result state machine has three states. `XR_IDLE` means no access. `XR_ISSUE` means the access is sent to memory. `XR_BLOCK` means the access is suppressed because the frame is out of range. From any state the next state is chosen the same way: no request goes to `XR_IDLE`, a request whose frame is in range goes to `XR_ISSUE`, and an on-board request whose frame is too large goes to `XR_BLOCK`. The host writes and reads map slots through its own index, write-enable and data lines.

Top module: `pagemap_xlate`

## Requirements
- R1: Address bits 23:20 have no effect. The slot is address bits 19:10, so two addresses that differ only in the top nibble give identical results.
- R2: One clock after a request, a granted access shows `*_go`=1 and `*_paddr` = {entry bits 11:0, address bits 9:1}.
- R3: Entry bit 15 is the byte-order bit. For a 16-bit access with bit 15 set, the two bytes of the write data are exchanged on `*_mdata`. With bit 15 clear the data passes unchanged. `*_bigend` shows bit 15.
- R4: For an 8-bit access, the lane is address bit 0 XOR entry bit 15. `*_be` is 2'b01 for lane 0 and 2'b10 for lane 1, and `*_mdata` carries write-data bits 7:0 in both bytes. A 16-bit access gives `*_be`=2'b11.
- R5: Entry bit 13 is the memory-select bit. `*_p2` shows it for every granted access: 1 means the secondary bus, 0 means on-board memory.
- R6: If entry bit 13 is clear and the frame number is 256 or above, the result is `*_oor`=1 with `*_go`=0, `*_be`=0 and all other result fields 0. With bit 13 set, no range check is made.
- R7: After reset every map slot reads 0, and a lookup translates to frame 0 with little-endian order on on-board memory.
- R8: `map_rdata` shows the slot selected by `map_idx` combinationally. A write made in one cycle is used by lookups from the next cycle on. A lookup in the same cycle as the write uses the old entry.
- R9: The controller port and the host port translate independently through the same map in the same cycle.
- R10: In the cycle after a cycle with no request, `*_go`, `*_oor` and all result fields are 0. This also holds during reset.
- R11: Slot 1023 covers the top of the space. With that slot aliased to frame 0, address 0xFFFFF4 gives the same physical address as offset 0x3F4 in frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_we | input | 1 | Host write strobe for a map slot |
| map_idx | input | 10 | Map slot for host read and write |
| map_wdata | input | 16 | Entry value to write |
| map_rdata | output | 16 | Entry at `map_idx` (combinational) |
| ctl_valid | input | 1 | Controller request |
| ctl_addr | input | 24 | Controller byte address |
| ctl_word | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| ctl_wdata | input | 16 | Controller write data |
| ctl_go | output | 1 | Controller access granted |
| ctl_oor | output | 1 | Controller access suppressed, frame out of range |
| ctl_paddr | output | 21 | Controller physical halfword address |
| ctl_p2 | output | 1 | Controller memory select |
| ctl_bigend | output | 1 | Controller byte order |
| ctl_be | output | 2 | Controller byte-lane enables |
| ctl_mdata | output | 16 | Controller steered write data |
| hst_valid | input | 1 | Host request |
| hst_addr | input | 24 | Host byte address |
| hst_word | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| hst_wdata | input | 16 | Host write data |
| hst_go | output | 1 | Host access granted |
| hst_oor | output | 1 | Host access suppressed, frame out of range |
| hst_paddr | output | 21 | Host physical halfword address |
| hst_p2 | output | 1 | Host memory select |
| hst_bigend | output | 1 | Host byte order |
| hst_be | output | 2 | Host byte-lane enables |
| hst_mdata | output | 16 | Host steered write data |

## Verification
Every translation result is due exactly one rising edge after the cycle in which its request is presented. `map_rdata` reflects a write right after the edge that performs it. The driver applies each cycle's stimulus on the falling edge and pushes one expected item per port per cycle, including idle items. The monitor pops and compares a short delay after the next rising edge, so every comparison falls in the cycle its result is due. The expected items come from a shadow copy of the map that is updated only after the same-cycle lookup has been predicted. This reproduces the old-entry behaviour of a lookup made during a write.

// File: rtl/pagemap_pkg.sv
package pagemap_pkg;
    // Map entry layout: byte-order bit, memory-select bit, frame number field
    localparam int ENT_W      = 16;
    localparam int ENT_BIGEND = 15;
    localparam int ENT_P2     = 13;

    typedef enum logic [1:0] {
        XR_IDLE  = 2'd0,
        XR_ISSUE = 2'd1,
        XR_BLOCK = 2'd2
    } xres_e;
endpackage

// File: rtl/pagemap_store.sv
module pagemap_store
    import pagemap_pkg::*;
#(
    parameter int SLOT_W = 10,
    parameter int NRD    = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [SLOT_W-1:0]           idx,
    input  logic [ENT_W-1:0]            wdata,
    output logic [ENT_W-1:0]            rdata,
    input  logic [NRD-1:0][SLOT_W-1:0]  rd_idx,
    output logic [NRD-1:0][ENT_W-1:0]   rd_ent
);
    localparam int SLOTS = 1 << SLOT_W;

    logic [ENT_W-1:0] tbl [SLOTS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) tbl[i] <= '0;
        end else if (we) begin
            tbl[idx] <= wdata;
        end
    end

    assign rdata = tbl[idx];

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_ent[g] = tbl[rd_idx[g]];
    end

    // R8
    map_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (rdata == $past(wdata)) || (idx != $past(idx)));
endmodule

// File: rtl/pagemap_lane.sv
module pagemap_lane #(
    parameter int DATA_W = 16
) (
    input  logic                word,
    input  logic                lane_bit,
    input  logic                swap,
    input  logic [DATA_W-1:0]   din,
    output logic [DATA_W/8-1:0] be,
    output logic [DATA_W-1:0]   dout
);
    localparam int LANES = DATA_W / 8;
    localparam int HALF  = DATA_W / 2;

    always_comb begin
        if (word) begin
            be   = '1;
            dout = swap ? {din[HALF-1:0], din[DATA_W-1:HALF]} : din;
        end else begin
            be   = LANES'(1) << (lane_bit ^ swap);
            dout = {LANES{din[7:0]}};
        end
    end

    // R4
    always_comb begin
        if (word == 1'b0) begin
            byte_lane_chk: assert ($countones(be) == 1);
        end
    end
endmodule

// File: rtl/pagemap_port.sv
module pagemap_port
    import pagemap_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int SLOT_W     = 10,
    parameter int OFS_W      = 10,
    parameter int PFN_W      = 12,
    parameter int NUM_FRAMES = 256,
    parameter int DATA_W     = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic                      req_word,
    input  logic [DATA_W-1:0]         req_wdata,
    output logic [SLOT_W-1:0]         slot,
    input  logic [ENT_W-1:0]          ent,
    output logic                      go,
    output logic                      oor,
    output logic [PFN_W+OFS_W-2:0]    paddr,
    output logic                      p2,
    output logic                      bigend,
    output logic [DATA_W/8-1:0]       be,
    output logic [DATA_W-1:0]         mdata
);
    localparam int PADDR_W = PFN_W + OFS_W - 1;
    localparam int LANES   = DATA_W / 8;
    localparam logic [PFN_W-1:0] FRAME_LIM = PFN_W'(NUM_FRAMES);

    xres_e state_q, state_d;

    logic [PFN_W-1:0]   pfn;
    logic               swap, on_p2, in_range;
    logic [LANES-1:0]   lane_be;
    logic [DATA_W-1:0]  lane_data;

    logic [PADDR_W-1:0] paddr_q;
    logic               p2_q, big_q;
    logic [LANES-1:0]   be_q;
    logic [DATA_W-1:0]  md_q;

    // slot select drops the top address bits above the map index
    assign slot     = req_addr[OFS_W+SLOT_W-1:OFS_W];
    assign pfn      = ent[PFN_W-1:0];
    assign swap     = ent[ENT_BIGEND];
    assign on_p2    = ent[ENT_P2];
    assign in_range = on_p2 || (pfn < FRAME_LIM);

    pagemap_lane #(.DATA_W(DATA_W)) u_lane (
        .word     (req_word),
        .lane_bit (req_addr[0]),
        .swap     (swap),
        .din      (req_wdata),
        .be       (lane_be),
        .dout     (lane_data)
    );

    // next-state logic: same decision from every state
    always_comb begin
        state_d = XR_IDLE;
        unique case (state_q)
            XR_IDLE, XR_ISSUE, XR_BLOCK: begin
                if (req_valid) state_d = in_range ? XR_ISSUE : XR_BLOCK;
            end
            default: state_d = XR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= XR_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            paddr_q <= '0;
            p2_q    <= 1'b0;
            big_q   <= 1'b0;
            be_q    <= '0;
            md_q    <= '0;
        end else if (req_valid && in_range) begin
            paddr_q <= {pfn, req_addr[OFS_W-1:1]};
            p2_q    <= on_p2;
            big_q   <= swap;
            be_q    <= lane_be;
            md_q    <= lane_data;
        end
    end

    // outputs decoded from the result state
    always_comb begin
        go     = 1'b0;
        oor    = 1'b0;
        paddr  = '0;
        p2     = 1'b0;
        bigend = 1'b0;
        be     = '0;
        mdata  = '0;
        unique case (state_q)
            XR_ISSUE: begin
                go     = 1'b1;
                paddr  = paddr_q;
                p2     = p2_q;
                bigend = big_q;
                be     = be_q;
                mdata  = md_q;
            end
            XR_BLOCK: oor = 1'b1;
            XR_IDLE:  ;
            default:  ;
        endcase
    end

    // R2
    issue_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (go || oor));
    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !(go || oor));
    // R6
    blocked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oor |-> (be == '0) && !go);
    // R4
    go_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !$past(req_word)) |-> ($countones(be) == 1));
endmodule

// File: rtl/pagemap_xlate.sv
module pagemap_xlate
    import pagemap_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int SLOT_W     = 10,
    parameter int OFS_W      = 10,
    parameter int PFN_W      = 12,
    parameter int NUM_FRAMES = 256,
    parameter int DATA_W     = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    map_we,
    input  logic [SLOT_W-1:0]       map_idx,
    input  logic [ENT_W-1:0]        map_wdata,
    output logic [ENT_W-1:0]        map_rdata,
    input  logic                    ctl_valid,
    input  logic [ADDR_W-1:0]       ctl_addr,
    input  logic                    ctl_word,
    input  logic [DATA_W-1:0]       ctl_wdata,
    output logic                    ctl_go,
    output logic                    ctl_oor,
    output logic [PFN_W+OFS_W-2:0]  ctl_paddr,
    output logic                    ctl_p2,
    output logic                    ctl_bigend,
    output logic [DATA_W/8-1:0]     ctl_be,
    output logic [DATA_W-1:0]       ctl_mdata,
    input  logic                    hst_valid,
    input  logic [ADDR_W-1:0]       hst_addr,
    input  logic                    hst_word,
    input  logic [DATA_W-1:0]       hst_wdata,
    output logic                    hst_go,
    output logic                    hst_oor,
    output logic [PFN_W+OFS_W-2:0]  hst_paddr,
    output logic                    hst_p2,
    output logic                    hst_bigend,
    output logic [DATA_W/8-1:0]     hst_be,
    output logic [DATA_W-1:0]       hst_mdata
);
    localparam int NPORT   = 2;
    localparam int PADDR_W = PFN_W + OFS_W - 1;
    localparam int LANES   = DATA_W / 8;

    logic [NPORT-1:0]              rq_v, rq_w, r_go, r_oor, r_p2, r_big;
    logic [NPORT-1:0][ADDR_W-1:0]  rq_a;
    logic [NPORT-1:0][DATA_W-1:0]  rq_d, r_md;
    logic [NPORT-1:0][SLOT_W-1:0]  p_slot;
    logic [NPORT-1:0][ENT_W-1:0]   p_ent;
    logic [NPORT-1:0][PADDR_W-1:0] r_pa;
    logic [NPORT-1:0][LANES-1:0]   r_be;

    // port 0 = controller, port 1 = host
    assign rq_v = {hst_valid, ctl_valid};
    assign rq_w = {hst_word,  ctl_word};
    assign rq_a = {hst_addr,  ctl_addr};
    assign rq_d = {hst_wdata, ctl_wdata};

    pagemap_store #(.SLOT_W(SLOT_W), .NRD(NPORT)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (map_we),
        .idx    (map_idx),
        .wdata  (map_wdata),
        .rdata  (map_rdata),
        .rd_idx (p_slot),
        .rd_ent (p_ent)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        pagemap_port #(
            .ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .OFS_W(OFS_W),
            .PFN_W(PFN_W), .NUM_FRAMES(NUM_FRAMES), .DATA_W(DATA_W)
        ) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_valid (rq_v[p]),
            .req_addr  (rq_a[p]),
            .req_word  (rq_w[p]),
            .req_wdata (rq_d[p]),
            .slot      (p_slot[p]),
            .ent       (p_ent[p]),
            .go        (r_go[p]),
            .oor       (r_oor[p]),
            .paddr     (r_pa[p]),
            .p2        (r_p2[p]),
            .bigend    (r_big[p]),
            .be        (r_be[p]),
            .mdata     (r_md[p])
        );
    end

    assign ctl_go     = r_go[0];
    assign ctl_oor    = r_oor[0];
    assign ctl_paddr  = r_pa[0];
    assign ctl_p2     = r_p2[0];
    assign ctl_bigend = r_big[0];
    assign ctl_be     = r_be[0];
    assign ctl_mdata  = r_md[0];
    assign hst_go     = r_go[1];
    assign hst_oor    = r_oor[1];
    assign hst_paddr  = r_pa[1];
    assign hst_p2     = r_p2[1];
    assign hst_bigend = r_big[1];
    assign hst_be     = r_be[1];
    assign hst_mdata  = r_md[1];
endmodule

// File: tb/pagemap_xlate_test.sv
`timescale 1ns/1ps
module pagemap_xlate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        map_we = 1'b0;
    logic [9:0]  map_idx = '0;
    logic [15:0] map_wdata = '0;
    logic [15:0] map_rdata;
    logic        ctl_valid = 1'b0, ctl_word = 1'b0;
    logic [23:0] ctl_addr = '0;
    logic [15:0] ctl_wdata = '0;
    logic        ctl_go, ctl_oor, ctl_p2, ctl_bigend;
    logic [20:0] ctl_paddr;
    logic [1:0]  ctl_be;
    logic [15:0] ctl_mdata;
    logic        hst_valid = 1'b0, hst_word = 1'b0;
    logic [23:0] hst_addr = '0;
    logic [15:0] hst_wdata = '0;
    logic        hst_go, hst_oor, hst_p2, hst_bigend;
    logic [20:0] hst_paddr;
    logic [1:0]  hst_be;
    logic [15:0] hst_mdata;

    always #10 clk = ~clk;

    pagemap_xlate uut (.*);

    typedef struct packed {
        logic        go;
        logic        oor;
        logic [20:0] paddr;
        logic        p2;
        logic        big;
        logic [1:0]  be;
        logic [15:0] md;
    } res_t;

    typedef struct {
        res_t  r;
        string rq;
    } item_t;

    typedef struct packed {
        logic        v;
        logic        word;
        logic [23:0] addr;
        logic [15:0] wd;
    } stim_t;

    int    checks = 0;
    int    errors = 0;
    logic [15:0] shadow [1024];
    item_t ctlq[$];
    item_t hstq[$];
    localparam stim_t IDLE = '0;

    function automatic res_t predict(stim_t s, logic [15:0] e);
        res_t r = '0;
        if (s.v) begin
            if (!e[13] && (e[11:0] >= 12'd256)) begin
                r.oor = 1'b1;
            end else begin
                r.go    = 1'b1;
                r.paddr = {e[11:0], s.addr[9:1]};
                r.p2    = e[13];
                r.big   = e[15];
                if (s.word) begin
                    r.be = 2'b11;
                    r.md = e[15] ? {s.wd[7:0], s.wd[15:8]} : s.wd;
                end else begin
                    r.be = (s.addr[0] ^ e[15]) ? 2'b10 : 2'b01;
                    r.md = {s.wd[7:0], s.wd[7:0]};
                end
            end
        end
        return r;
    endfunction

    function automatic stim_t mk(logic word, logic [23:0] a, logic [15:0] d);
        stim_t s;
        s.v = 1'b1; s.word = word; s.addr = a; s.wd = d;
        return s;
    endfunction

    function automatic string fmt(res_t r);
        return $sformatf("go=%0b oor=%0b pa=%h p2=%0b big=%0b be=%b md=%h",
                         r.go, r.oor, r.paddr, r.p2, r.big, r.be, r.md);
    endfunction

    // driver: one cycle of stimulus, expected items pushed for both ports
    task automatic step(stim_t c, stim_t h, logic we, logic [9:0] idx,
                        logic [15:0] wd, string rq);
        item_t ic, ih;
        @(negedge clk);
        ctl_valid = c.v; ctl_word = c.word; ctl_addr = c.addr; ctl_wdata = c.wd;
        hst_valid = h.v; hst_word = h.word; hst_addr = h.addr; hst_wdata = h.wd;
        map_we = we; map_idx = idx; map_wdata = wd;
        ic.r = predict(c, shadow[c.addr[19:10]]); ic.rq = rq;
        ih.r = predict(h, shadow[h.addr[19:10]]); ih.rq = rq;
        ctlq.push_back(ic);
        hstq.push_back(ih);
        if (we) shadow[idx] = wd;
    endtask

    task automatic wr(logic [9:0] idx, logic [15:0] wd);
        step(IDLE, IDLE, 1'b1, idx, wd, "R8");
        step(IDLE, IDLE, 1'b0, idx, '0, "R10");
        #1;
        checks++;
        if (map_rdata !== wd) begin
            errors++;
            $display("FAIL R8 map_rdata slot %0d actual %h expected %h", idx, map_rdata, wd);
        end
    endtask

    task automatic cmp(string port, item_t it, res_t act);
        checks++;
        if (act !== it.r) begin
            errors++;
            $display("FAIL %s %s actual %s expected %s", it.rq, port, fmt(act), fmt(it.r));
        end
    endtask

    // monitor: compare just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (ctlq.size() > 0)
                cmp("ctl", ctlq.pop_front(),
                    {ctl_go, ctl_oor, ctl_paddr, ctl_p2, ctl_bigend, ctl_be, ctl_mdata});
            if (hstq.size() > 0)
                cmp("hst", hstq.pop_front(),
                    {hst_go, hst_oor, hst_paddr, hst_p2, hst_bigend, hst_be, hst_mdata});
        end
    end

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog all requirements actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        checks++;
        if ({ctl_go, ctl_oor, hst_go, hst_oor, ctl_be, hst_be} !== '0) begin
            errors++;
            $display("FAIL R10 outputs in reset actual %b expected 0",
                     {ctl_go, ctl_oor, hst_go, hst_oor, ctl_be, hst_be});
        end
        rst_n = 1'b1;

        // R7: map cleared by reset
        step(IDLE, IDLE, 1'b0, 10'd0, '0, "R7");
        #1; checks++;
        if (map_rdata !== 16'h0) begin
            errors++; $display("FAIL R7 slot 0 actual %h expected 0000", map_rdata);
        end
        step(IDLE, IDLE, 1'b0, 10'd1023, '0, "R7");
        #1; checks++;
        if (map_rdata !== 16'h0) begin
            errors++; $display("FAIL R7 slot 1023 actual %h expected 0000", map_rdata);
        end
        step(mk(1, 24'h012345, 16'h1234), mk(0, 24'h3FF001, 16'h00AB), 1'b0, '0, '0, "R7");

        // program the map (R8)
        wr(10'd5,    16'h8023);   // big-endian, frame 0x23
        wr(10'd6,    16'h0040);   // little-endian, frame 0x40
        wr(10'd7,    16'h29AB);   // secondary bus, frame beyond on-board range
        wr(10'd8,    16'h0100);   // on-board frame 256: out of range
        wr(10'd9,    16'h00FF);   // last legal on-board frame
        wr(10'd1023, 16'h8000);   // alias of frame 0 at top of space

        // R8: write and lookup in the same cycle, then the cycle after
        step(mk(1, 24'h002806, 16'h5566), IDLE, 1'b1, 10'd10, 16'h0011, "R8");
        step(mk(1, 24'h002806, 16'h5566), IDLE, 1'b0, 10'd10, '0, "R8");

        // R1: top nibble ignored
        step(mk(1, 24'hF01402, 16'hA1B2), mk(1, 24'h301402, 16'hA1B2), 1'b0, '0, '0, "R1");
        // R2 and R3: word swap versus pass-through
        step(mk(1, 24'h001402, 16'hA1B2), mk(1, 24'h0019FE, 16'hA1B2), 1'b0, '0, '0, "R3");
        // R4: byte lanes for both byte orders
        step(mk(0, 24'h001800, 16'h00C3), mk(0, 24'h001801, 16'h00C3), 1'b0, '0, '0, "R4");
        step(mk(0, 24'h001400, 16'h007E), mk(0, 24'h001401, 16'h007E), 1'b0, '0, '0, "R4");
        // R5: secondary bus select, no range check
        step(mk(1, 24'h001C10, 16'h0F0F), mk(0, 24'h001C11, 16'h0099), 1'b0, '0, '0, "R5");
        // R6: out of range versus last legal frame
        step(mk(1, 24'h002000, 16'hFFFF), mk(1, 24'h002400, 16'hFFFF), 1'b0, '0, '0, "R6");
        step(mk(0, 24'h8023FF, 16'h0001), IDLE, 1'b0, '0, '0, "R6");
        // R10: idle cycle after a blocked access
        step(IDLE, IDLE, 1'b0, '0, '0, "R10");
        // R9: both ports, different slots, same cycle
        step(mk(1, 24'h001406, 16'h1122), mk(1, 24'h00270A, 16'h3344), 1'b0, '0, '0, "R9");
        // R11: configuration pointer address via aliased top slot, and frame 0 direct
        step(mk(1, 24'hFFFFF4, 16'h0000), mk(1, 24'h0003F4, 16'h0000), 1'b0, '0, '0, "R11");
        // R2: back-to-back on controller
        step(mk(1, 24'h002402, 16'hBEEF), IDLE, 1'b0, '0, '0, "R2");
        step(mk(1, 24'h0027FE, 16'hCAFE), IDLE, 1'b0, '0, '0, "R2");

        repeat (3) step(IDLE, IDLE, 1'b0, '0, '0, "R10");
        while (ctlq.size() > 0 || hstq.size() > 0) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule